// File: doc/BRIEF.md
# Paged Fetch Address Generator with Single-Level Call

This block produces the instruction fetch address and the data address for a small 8-bit accumulator machine. A 5-bit offset counter and a 4-bit page register together form a 9-bit address, so the machine can reach 512 bytes of program space. When the offset counter wraps, the page register advances by one. Plain jumps reload only the offset, so they stay inside the current page.

The store opcode does not write memory when its operand is below 0x10. The decoder raises `longst_i` for these stores. In that case the store becomes a control transfer:
- Operand 0x0F is a return.
- Any other such operand is a call to the page named by the operand's low four bits.

The block holds two offset/page pairs and a one-bit selector. A call moves execution to pair 1 and starts it at offset 0 of the target page. Pair 0 keeps the address of the instruction after the call. A return sets the selector back to pair 0, and fetching resumes there.

The data address comes from the operand. The upper half of each 32-byte window maps to one shared 16-byte read/write area in page zero. The lower half maps to read-only bytes in the current page.

Top module: `paged_fetch_ctrl`

## Requirements
- R1: While `rst_n` is low and after reset, `fetch_addr_o` is 0x000 and `pair_o` is 0. Both pairs are cleared.
- R2: With `step_i` high and no other request, the active pair's 9-bit address {page, offset} increases by one at each rising clock edge.
- R3: Stepping from offset 0x1F clears the offset and adds one to the page. Stepping from 0x1FF gives 0x000.
- R4: `sjmp_i` loads `sjmp_tgt_i` into the active offset and leaves the active page and `pair_o` unchanged.
- R5: `longst_i` with `oper_i` in 0x00..0x0E is a call:
  - `pair_o` becomes 1.
  - `fetch_addr_o` becomes `oper_i[3:0]` × 32.
  - Pair 0 is left untouched.
- R6: `longst_i` with `oper_i` = 0x0F while `pair_o` is 1 sets `pair_o` to 0. The fetch address becomes the value pair 0 held unchanged since the call.
- R7: A call while `pair_o` is 1 is a long jump inside pair 1. The saved pair 0 address survives, so a later return still reaches it.
- R8: A return while `pair_o` is 0 changes neither `fetch_addr_o` nor `pair_o`.
- R9: `data_addr_o` is {0000, `oper_i`} when `oper_i[4]` is 1. When `oper_i[4]` is 0 it is {active page, `oper_i`}.
- R10: When requests coincide, priority runs `longst_i` first, then `sjmp_i`, then `step_i`.
- R11: `longst_i` with `oper_i[4]` = 1 is ignored. The pairs and the selector keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Advance the active address by one |
| longst_i | input | 1 | Decoded store whose operand selects call or return |
| oper_i | input | 5 | Instruction operand (store code or data offset) |
| sjmp_i | input | 1 | Short jump strobe |
| sjmp_tgt_i | input | 5 | Short jump target offset |
| fetch_addr_o | output | 9 | Instruction fetch address {page, offset} |
| data_addr_o | output | 9 | Mapped data address |
| pair_o | output | 1 | Index of the active offset/page pair |

## Verification
Several properties are checked on every cycle:
- The page carry and the page-preserving short jump.
- An idle pair holding its value, which covers both the saved return address and the inactive pair.
- Where a call lands.
- A return restoring pair 0's address.
- A return from pair 0, and a store with a high operand, both having no effect.

Only the bench's scenarios can show the longer sequences. These include a nested call that overwrites pair 1 while the original return point survives, the wrap from the last address to zero, and the priority order when all three requests arrive in the same cycle.

// File: rtl/pagepc_pkg.sv
package pagepc_pkg;
  localparam int NPAIR = 2;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_JUMP = 2'd2,
    ACT_LONG = 2'd3
  } pair_act_e;
endpackage

// File: rtl/pc_pair.sv
module pc_pair
  import pagepc_pkg::*;
#(
  parameter int OFS_W = 5,
  parameter int PG_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pair_act_e        act_i,
  input  logic [OFS_W-1:0] tgt_ofs_i,
  input  logic [PG_W-1:0]  tgt_pg_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic [PG_W-1:0]  pg_o
);
  localparam int AW = OFS_W + PG_W;

  logic [OFS_W-1:0] ofs_q;
  logic [PG_W-1:0]  pg_q;

  // linear successor: offset carry ripples into the page
  function automatic logic [AW-1:0] next_lin(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q <= '0;
      pg_q  <= '0;
    end else begin
      case (act_i)
        ACT_STEP: {pg_q, ofs_q} <= next_lin({pg_q, ofs_q});
        ACT_JUMP: ofs_q <= tgt_ofs_i;
        ACT_LONG: begin
          pg_q  <= tgt_pg_i;
          ofs_q <= '0;
        end
        default: ;
      endcase
    end
  end

  assign ofs_o = ofs_q;
  assign pg_o  = pg_q;

  assert_page_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_STEP && (&ofs_q)) |=> (ofs_q == '0 && pg_q == PG_W'($past(pg_q) + 1'b1)));

  assert_jump_keeps_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_JUMP) |=> (pg_q == $past(pg_q) && ofs_q == $past(tgt_ofs_i)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_HOLD) |=> $stable({pg_q, ofs_q}));
endmodule

// File: rtl/pair_select.sv
module pair_select (
  input  logic clk,
  input  logic rst_n,
  input  logic call_i,
  input  logic ret_i,
  output logic sel_o
);
  logic sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (call_i) sel_q <= 1'b1;
    else if (ret_i)  sel_q <= 1'b0;
  end

  assign sel_o = sel_q;

  assert_call_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |=> sel_q);
endmodule

// File: rtl/data_map.sv
module data_map #(
  parameter int OFS_W = 5,
  parameter int PG_W  = 4
) (
  input  logic [OFS_W-1:0]      oper_i,
  input  logic [PG_W-1:0]       cur_pg_i,
  output logic [OFS_W+PG_W-1:0] daddr_o
);
  logic shared_w;

  assign shared_w = oper_i[OFS_W-1];

  always_comb begin
    daddr_o = shared_w ? {PG_W'(0), oper_i} : {cur_pg_i, oper_i};
  end

  always_comb begin
    if (shared_w) begin
      assert_shared_ram_R9: assert (daddr_o[OFS_W+PG_W-1:OFS_W] == '0);
    end
  end
endmodule

// File: rtl/paged_fetch_ctrl.sv
module paged_fetch_ctrl
  import pagepc_pkg::*;
#(
  parameter int OFS_W = 5,
  parameter int PG_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step_i,
  input  logic                  longst_i,
  input  logic [OFS_W-1:0]      oper_i,
  input  logic                  sjmp_i,
  input  logic [OFS_W-1:0]      sjmp_tgt_i,
  output logic [OFS_W+PG_W-1:0] fetch_addr_o,
  output logic [OFS_W+PG_W-1:0] data_addr_o,
  output logic                  pair_o
);
  localparam int AW = OFS_W + PG_W;
  localparam logic [PG_W-1:0] RET_CODE = {PG_W{1'b1}};

  logic             ctl_w, ret_w, call_w, sel_w;
  logic [OFS_W-1:0] ofs_a [NPAIR];
  logic [PG_W-1:0]  pg_a  [NPAIR];
  logic [PG_W-1:0]  cur_pg_w;

  // store-low decode: operand MSB must be clear to act as control transfer
  assign ctl_w  = longst_i & ~oper_i[OFS_W-1];
  assign ret_w  = ctl_w & (oper_i[PG_W-1:0] == RET_CODE);
  assign call_w = ctl_w & ~ret_w;

  pair_select u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .call_i (call_w),
    .ret_i  (ret_w),
    .sel_o  (sel_w)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pair_act_e act;
    always_comb begin
      act = ACT_HOLD;
      if (ctl_w) begin
        if (call_w && p == NPAIR - 1) act = ACT_LONG;
      end else if (sel_w == p[0]) begin
        if (sjmp_i)      act = ACT_JUMP;
        else if (step_i) act = ACT_STEP;
      end
    end

    pc_pair #(.OFS_W(OFS_W), .PG_W(PG_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (act),
      .tgt_ofs_i (sjmp_tgt_i),
      .tgt_pg_i  (oper_i[PG_W-1:0]),
      .ofs_o     (ofs_a[p]),
      .pg_o      (pg_a[p])
    );
  end

  assign cur_pg_w     = sel_w ? pg_a[1] : pg_a[0];
  assign fetch_addr_o = sel_w ? {pg_a[1], ofs_a[1]} : {pg_a[0], ofs_a[0]};
  assign pair_o       = sel_w;

  data_map #(.OFS_W(OFS_W), .PG_W(PG_W)) u_dmap (
    .oper_i   (oper_i),
    .cur_pg_i (cur_pg_w),
    .daddr_o  (data_addr_o)
  );

  assert_call_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    call_w |=> (pair_o && fetch_addr_o == {$past(oper_i[PG_W-1:0]), OFS_W'(0)}));

  assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_w && pair_o) |=> (!pair_o && fetch_addr_o == $past({pg_a[0], ofs_a[0]})));

  assert_ret_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_w && !pair_o) |=> (!pair_o && $stable(fetch_addr_o)));

  assert_high_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (longst_i && oper_i[OFS_W-1] && !sjmp_i && !step_i) |=> ($stable(fetch_addr_o) && $stable(pair_o)));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (fetch_addr_o == '0 && !pair_o));
endmodule

// File: tb/tb_paged_fetch_ctrl.sv
module tb_paged_fetch_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_i = 1'b0, longst_i = 1'b0, sjmp_i = 1'b0;
  logic [4:0] oper_i = '0, sjmp_tgt_i = '0;
  logic [8:0] fetch_addr_o, data_addr_o;
  logic       pair_o;

  paged_fetch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .longst_i(longst_i),
    .oper_i(oper_i), .sjmp_i(sjmp_i), .sjmp_tgt_i(sjmp_tgt_i),
    .fetch_addr_o(fetch_addr_o), .data_addr_o(data_addr_o), .pair_o(pair_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    due;
    int    fetch;
    int    daddr;
    int    pair;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  // independent model: linear addresses per pair
  int mlin [2];
  int msel;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares items after their edge, away from the edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, int'(fetch_addr_o), e.fetch, "fetch");
      check(e.tag, int'(data_addr_o), e.daddr, "daddr");
      check(e.tag, int'(pair_o), e.pair, "pair");
    end
  end

  task automatic drive(input bit ls, input int op, input bit jp, input int tgt,
                       input bit st, input string tag);
    exp_t e;
    longst_i = ls; oper_i = op[4:0]; sjmp_i = jp; sjmp_tgt_i = tgt[4:0]; step_i = st;
    if (ls && op < 16) begin
      if (op == 15) msel = 0;
      else begin msel = 1; mlin[1] = op * 32; end
    end else if (jp) begin
      mlin[msel] = (mlin[msel] / 32) * 32 + tgt;
    end else if (st) begin
      mlin[msel] = (mlin[msel] + 1) % 512;
    end
    e.due   = cyc + 1;
    e.fetch = mlin[msel];
    e.daddr = (op >= 16) ? op : (mlin[msel] / 32) * 32 + op;
    e.pair  = msel;
    e.tag   = tag;
    q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mlin[0] = 0; mlin[1] = 0; msel = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(fetch_addr_o), 0, "fetch in reset");
    check("R1", int'(pair_o), 0, "pair in reset");
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1", int'(fetch_addr_o), 0, "fetch after reset");

    drive(0, 0, 0, 0, 1, "R2");
    drive(0, 0, 0, 0, 1, "R2");
    drive(0, 0, 0, 0, 1, "R2");
    drive(0, 0, 1, 30, 0, "R4");
    drive(0, 0, 0, 0, 1, "R2");
    drive(0, 0, 0, 0, 1, "R3");       // 0x1F -> 0x20
    drive(0, 5, 0, 0, 0, "R9");       // read-only half, page 1
    drive(0, 19, 0, 0, 0, "R9");      // shared RAM half
    drive(1, 3, 0, 0, 0, "R5");       // call page 3
    drive(0, 0, 0, 0, 1, "R2");
    drive(0, 0, 1, 31, 0, "R4");
    drive(0, 0, 0, 0, 1, "R3");
    drive(1, 14, 0, 0, 0, "R7");      // nested call inside pair 1
    drive(0, 0, 0, 0, 1, "R7");
    drive(1, 15, 0, 0, 0, "R6");      // return to 0x020
    drive(1, 15, 0, 0, 0, "R8");      // return from pair 0 ignored
    drive(1, 21, 0, 0, 0, "R11");     // high operand ignored
    drive(1, 2, 1, 7, 1, "R10");      // call wins over jump and step
    drive(0, 0, 1, 9, 1, "R10");      // jump wins over step
    drive(1, 14, 0, 0, 0, "R5");
    drive(0, 0, 1, 31, 0, "R4");
    drive(0, 0, 0, 0, 1, "R3");       // into page F
    drive(0, 0, 1, 31, 0, "R4");
    drive(0, 0, 0, 0, 1, "R3");       // 0x1FF -> 0x000
    drive(0, 0, 0, 0, 0, "R8");
    drive(1, 15, 0, 0, 0, "R6");      // return restores pair 0 (0x020)
    drive(0, 0, 0, 0, 0, "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule